// File: doc/BRIEF.md
# Buffered Edge Event Counter

This block counts transitions of an asynchronous event input rather than system clocks. Software chooses which transitions count (rising, falling, both or none), selects the event-count mode, loads a period value, and sets an enable bit. Every (period + 1) qualifying transitions the block issues a one-clock interrupt pulse and the count returns to zero. The live count is always visible on an output port.

The period value is held in a programmable register and copied into an internal shadow buffer when counting is switched on. Matches are compared against that shadow. The shadow reloads on each match, so software may change the period while counting runs without disturbing the period in progress. Control and period writes use single-cycle synchronous strobes.

Top module: `edge_event_counter`

## Requirements
- R1: After reset the count output reads FFFFh and the interrupt output is low.
- R2: A control write with the enable bit set, while the block is disabled, makes the count read 0000h on the next cycle. A control write that sets the enable bit while the block is already enabled leaves the count unchanged.
- R3: The edge field selects the qualifying transitions: 00 none, 01 low-to-high, 10 high-to-low, 11 both.
- R4: The event input passes through a two-stage synchronizer. Each qualifying transition raises the count by exactly one, and the count never moves by any other step than +1 or a clear to 0000h.
- R5: When a qualifying transition arrives while the count equals the buffered period, the count clears to 0000h and an interrupt pulse follows. With period N, one interrupt occurs per N+1 qualifying transitions.
- R6: The interrupt pulse is high for exactly one clock cycle.
- R7: Enabling copies the period register into the buffer. A period write made while counting takes effect only after the next match.
- R8: While the enable bit is clear, the count holds its value and transitions are ignored.
- R9: A mode field value other than 001 holds the count idle even when enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit written by ctl_we |
| ctl_edge | input | 2 | Edge select written by ctl_we |
| ctl_mode | input | 3 | Mode field written by ctl_we (001 = event count) |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 16 | Period value written by per_we |
| evt_in | input | 1 | Asynchronous event input |
| match_irq | output | 1 | One-cycle match interrupt pulse |
| count_q | output | 16 | Live count value |

## Verification
The bench builds the block with its default parameters: a 16-bit count and a two-stage synchronizer. It uses period values 0 through 4, so several matches and wraps occur within a dozen transitions, and the reset-to-enable transition from FFFFh to 0000h can be seen directly. The bench sweeps every edge encoding against every one of these periods. It also covers period changes made in mid-period, restart attempts while already enabled, idle modes and disabled operation.

// File: rtl/evc_pkg.sv
// Shared encodings for the edge event counter.
// Assumes: mode and edge field widths are fixed by the control layout.
package evc_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_EVENT = 3'b001;
endpackage

// File: rtl/evc_sync.sv
// Multi-stage synchronizer for an asynchronous single-bit input.
// Assumes: STAGES >= 2; output is reset low.
module evc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/evc_edge_det.sv
// Qualifies transitions of a synchronized signal against the edge select.
// Assumes: input is already synchronous; yields at most one pulse per clock.
module evc_edge_det
    import evc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_sync,
    input  edge_sel_e edge_sel,
    output logic      evt_pulse
);
    logic prev_q;
    logic rise, fall;

    // Remember the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_sync;
    end

    assign rise = sig_sync & ~prev_q;
    assign fall = ~sig_sync & prev_q;

    // Pick the qualifying transitions.
    always_comb begin
        unique case (edge_sel)
            EDGE_NONE: evt_pulse = 1'b0;
            EDGE_RISE: evt_pulse = rise;
            EDGE_FALL: evt_pulse = fall;
            EDGE_BOTH: evt_pulse = rise | fall;
        endcase
    end
endmodule

// File: rtl/evc_count_core.sv
// Count register, period shadow buffer and match pulse generation.
// Assumes: start and run come from the control register; evt_pulse lasts one cycle.
module evc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             evt_pulse,
    input  logic [CNT_W-1:0] per_reg,
    output logic [CNT_W-1:0] count_q,
    output logic             match_irq
);
    localparam logic [CNT_W-1:0] CNT_INIT = '1;

    logic [CNT_W-1:0] per_buf_q;
    logic             hit;

    assign hit = run && evt_pulse && (count_q == per_buf_q);

    // Advance, clear or restart the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                count_q <= CNT_INIT;
        else if (start)            count_q <= '0;
        else if (hit)              count_q <= '0;
        else if (run && evt_pulse) count_q <= count_q + 1'b1;
    end

    // Load the shadow period at start and after each match.
    always_ff @(posedge clk) begin
        if (!rst_n)            per_buf_q <= CNT_INIT;
        else if (start || hit) per_buf_q <= per_reg;
    end

    // Register the match as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) match_irq <= 1'b0;
        else        match_irq <= hit && !start;
    end
endmodule

// File: rtl/edge_event_counter.sv
// Top of the edge event counter: control and period registers plus datapath.
// Assumes: writes are single-cycle strobes; evt_in is asynchronous to clk.
module edge_event_counter
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic [1:0]       ctl_edge,
    input  logic [2:0]       ctl_mode,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic             evt_in,
    output logic             match_irq,
    output logic [CNT_W-1:0] count_q
);
    logic              en_q;
    edge_sel_e         edge_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  per_q;
    logic              start, run, evt_sync, evt_pulse;

    assign start = ctl_we && ctl_en && !en_q;
    assign run   = en_q && (mode_q == MODE_EVENT);

    // Hold the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            edge_q <= EDGE_NONE;
            mode_q <= '0;
        end else if (ctl_we) begin
            en_q   <= ctl_en;
            edge_q <= edge_sel_e'(ctl_edge);
            mode_q <= ctl_mode;
        end
    end

    // Hold the programmed period.
    always_ff @(posedge clk) begin
        if (!rst_n)      per_q <= '1;
        else if (per_we) per_q <= per_wdata;
    end

    evc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (evt_in),
        .sync_out (evt_sync)
    );

    evc_edge_det i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_sync  (evt_sync),
        .edge_sel  (edge_q),
        .evt_pulse (evt_pulse)
    );

    evc_count_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run       (run),
        .evt_pulse (evt_pulse),
        .per_reg   (per_q),
        .count_q   (count_q),
        .match_irq (match_irq)
    );
endmodule

// File: rtl/evc_checks.sv
// Property checker for edge_event_counter, attached by bind.
// Assumes: sees the top's ports and its start/run control signals.
module evc_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             run,
    input logic             match_irq,
    input logic [CNT_W-1:0] count_q
);
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |=> !match_irq);

    // R5
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> (count_q == '0));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == '0));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_q) |-> ((count_q == $past(count_q) + 1'b1) || (count_q == '0)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(count_q));
endmodule

bind edge_event_counter evc_checks #(.CNT_W(CNT_W)) i_evc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run       (run),
    .match_irq (match_irq),
    .count_q   (count_q)
);

// File: tb/test_edge_event_counter.sv
module test_edge_event_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ctl_en = 1'b0, per_we = 1'b0, evt_in = 1'b0;
    logic [1:0]  ctl_edge = 2'b00;
    logic [2:0]  ctl_mode = 3'b000;
    logic [15:0] per_wdata = 16'h0;
    logic        match_irq;
    logic [15:0] count_q;

    int tests = 0, fails = 0;
    int irq_seen = 0;
    logic irq_prev = 1'b0;

    // model state
    int m_cnt, m_buf, m_reg, m_irq;
    logic [1:0] m_sel;
    bit m_run;

    edge_event_counter i_edge_event_counter (.*);

    always #10 clk = ~clk;

    // Count interrupt pulses and check pulse width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (match_irq) irq_seen++;
            if (match_irq && irq_prev) begin
                fails++; tests++;
                $display("FAIL R6: irq high two cycles, actual 1 expected 0");
            end
        end
        irq_prev = match_irq;
    end

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: run hung, actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input bit en, input logic [1:0] sel, input logic [2:0] mode);
        @(negedge clk);
        ctl_we = 1; ctl_en = en; ctl_edge = sel; ctl_mode = mode;
        @(negedge clk);
        ctl_we = 0;
        if (en && !m_run) begin m_cnt = 0; m_buf = m_reg; end
        m_run = en && (mode == 3'b001);
        m_sel = sel;
    endtask

    task automatic wr_per(input int v);
        @(negedge clk);
        per_we = 1; per_wdata = v[15:0];
        @(negedge clk);
        per_we = 0;
        m_reg = v;
    endtask

    // Toggle the event input and update the model.
    task automatic toggle(input string req);
        bit rise, valid;
        evt_in = ~evt_in;
        rise = evt_in;
        valid = (m_sel[0] && rise) || (m_sel[1] && !rise);
        repeat (5) @(negedge clk);
        if (m_run && valid) begin
            if (m_cnt == m_buf) begin m_cnt = 0; m_irq++; m_buf = m_reg; end
            else m_cnt++;
        end
        chk(req, count_q, m_cnt);
    endtask

    initial begin
        m_reg = 16'hFFFF; m_buf = 16'hFFFF; m_cnt = 16'hFFFF; m_irq = 0; m_sel = 0; m_run = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count_q, 16'hFFFF);
        chk("R1 irq", match_irq, 0);

        // R3 R4 R5 sweep of every edge encoding against periods 0..4
        for (int sel = 0; sel < 4; sel++) begin
            for (int n = 0; n < 5; n++) begin
                wr_ctl(0, 2'(sel), 3'b001);
                wr_per(n);
                m_irq = 0; irq_seen = 0;
                wr_ctl(1, 2'(sel), 3'b001);
                chk("R2 enable clears", count_q, 0);
                for (int k = 0; k < 12; k++) toggle("R3 R4 R5 count");
                chk("R5 irq total", irq_seen, m_irq);
            end
        end

        // R2 repeated enable write does not clear
        wr_ctl(0, 2'b11, 3'b001);
        wr_per(9);
        wr_ctl(1, 2'b11, 3'b001);
        toggle("R4 count"); toggle("R4 count"); toggle("R4 count");
        wr_ctl(1, 2'b11, 3'b001);
        chk("R2 re-enable keeps count", count_q, 3);

        // R7 period written mid-period waits for the next match
        wr_ctl(0, 2'b11, 3'b001);
        wr_per(3);
        m_irq = 0; irq_seen = 0;
        wr_ctl(1, 2'b11, 3'b001);
        toggle("R7 count"); toggle("R7 count");
        wr_per(1);
        toggle("R7 count"); toggle("R7 count");
        chk("R7 old period still used", irq_seen, 1);
        toggle("R7 count"); toggle("R7 count");
        chk("R7 new period after match", irq_seen, 2);
        chk("R7 model irq", irq_seen, m_irq);

        // R8 disabled: count holds, edges ignored
        wr_ctl(0, 2'b11, 3'b001);
        for (int k = 0; k < 4; k++) toggle("R8 hold");
        chk("R8 no irq while disabled", irq_seen, m_irq);

        // R9 non-event mode idles the counter
        for (int md = 0; md < 8; md++) begin
            if (md == 1) continue;
            wr_ctl(0, 2'b11, 3'(md));
            wr_ctl(1, 2'b11, 3'(md));
            chk("R9 start clears", count_q, 0);
            toggle("R9 idle"); toggle("R9 idle");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule